// File: doc/BRIEF.md
# Auto-Incrementing Palette Index Port

This block gives a processor byte-wide access to color palette storage through two small register pairs. One pair serves the background palette and one serves the object palette. Each pair has an index register, which selects an entry, and a data register, which reads or writes that entry. The two pairs share one 128-byte palette store. The background pair reaches entries 0 to 63 and the object pair reaches entries 64 to 127.

Software writes an index, with bit 7 set if it wants auto-increment. It then streams palette bytes through the data register. With the flag set, each data write advances the 6-bit index and wraps from 63 to 0, so a whole palette loads with one index write followed by 64 data writes. Bit 6 of the index is a permanent hole that always reads as zero.

A mode input gates the whole block. When color mode is off, the four registers ignore writes and read as 0xFF. A separate combinational read port lets the pixel pipeline fetch any of the 128 stored bytes.

Top module: `pal_index_ports`

## Requirements
- R1: After reset, with color mode on, both index registers and both data registers read 0x00.
- R2: A write to an index register stores the written byte ANDed with 0xBF. Bit 6 reads back 0, and bit 7 and bits 5:0 read back as written.
- R3: A write to an index register also reloads that port's data register from palette entry (port base + written bits 5:0). The next read of the data register returns that entry.
- R4: A data write stores the byte at entry (port base + index bits 5:0). The background base is 0 and the object base is 64. From the next cycle the stored byte appears on the pixel read port at that entry.
- R5: A data write with index bit 7 set advances index bits 5:0 by one, wrapping from 63 to 0, and keeps bit 7 at 1. With bit 7 clear, the index does not change.
- R6: With color mode off, writes to the four register addresses change no index, data register or palette entry, and reads of those addresses return 0xFF.
- R7: A data register read returns the last value loaded or written. Reads change no register.
- R8: The register addresses are ADDR_BASE+0 (background index), +1 (background data), +2 (object index) and +3 (object data). Any other address reads 0xFF, and writes to it change nothing.
- R9: A write to one port changes neither register of the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_mode | input | 1 | Enables the four registers when high |
| io_addr | input | 8 | Register address (low byte) |
| io_wr | input | 1 | Write strobe, one write per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for io_addr |
| pix_addr | input | 7 | Pixel-side palette entry select |
| pix_data | output | 8 | Palette byte at pix_addr |

## Verification
The assertions assume that io_wr is a single-cycle-qualified strobe. They also assume that color_mode and io_addr are stable and known while the clock is sampled. The bench meets this by driving every input on the falling edge and holding it for a full cycle. Palette contents are never compared before they are written: the reset leaves the store undefined, so the stimulus fills all 128 entries before any read of the pixel port or any index reload is checked. The index sweeps cover all 256 written values on both ports, which exercises the bit-6 hole and the wrap from 63.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] READ_FILL = 8'hFF;
    localparam int FLAG_BIT = 7;

    typedef struct packed {
        logic sel_idx;
        logic sel_dat;
    } port_hit_t;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
    } port_wr_t;
endpackage

// File: rtl/pal_addr_decode.sv
module pal_addr_decode
    import pal_pkg::*;
#(
    parameter int NPORT = 2,
    parameter logic [7:0] ADDR_BASE = 8'h68
) (
    input  logic                         color_mode,
    input  logic [7:0]                   io_addr,
    input  logic                         io_wr,
    output port_hit_t [NPORT-1:0]        hit,
    output port_wr_t  [NPORT-1:0]        wr,
    output logic                         any_hit
);
    always_comb begin
        any_hit = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            hit[p].sel_idx = color_mode && (io_addr == 8'(ADDR_BASE + 2*p));
            hit[p].sel_dat = color_mode && (io_addr == 8'(ADDR_BASE + 2*p + 1));
            wr[p].idx_wr   = io_wr && hit[p].sel_idx;
            wr[p].dat_wr   = io_wr && hit[p].sel_dat;
            any_hit        = any_hit | hit[p].sel_idx | hit[p].sel_dat;
        end
    end
endmodule

// File: rtl/pal_index_port.sv
module pal_index_port
    import pal_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  port_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ent_rdata,
    output logic [IDX_W-1:0]  ent_raddr,
    output logic              ent_we,
    output logic [IDX_W-1:0]  ent_waddr,
    output logic [DATA_W-1:0] idx_q,
    output logic [DATA_W-1:0] dat_q
);
    localparam logic [DATA_W-1:0] LOW_MASK  = DATA_W'((1 << IDX_W) - 1);
    localparam logic [DATA_W-1:0] KEEP_MASK = LOW_MASK | DATA_W'(1 << FLAG_BIT);

    logic [DATA_W-1:0] idx_adv;

    always_comb begin
        idx_adv = (idx_q & DATA_W'(1 << FLAG_BIT)) |
                  (DATA_W'(idx_q[IDX_W-1:0] + IDX_W'(1)) & LOW_MASK);
        ent_raddr = wdata[IDX_W-1:0];
        ent_we    = wr.dat_wr;
        ent_waddr = idx_q[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            dat_q <= '0;
        end else if (wr.idx_wr) begin
            idx_q <= wdata & KEEP_MASK;
            dat_q <= ent_rdata;
        end else if (wr.dat_wr) begin
            dat_q <= wdata;
            if (idx_q[FLAG_BIT]) idx_q <= idx_adv;
        end
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int NRD    = 3
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]    raddr,
    output logic [NRD-1:0][DATA_W-1:0]    rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end
endmodule

// File: rtl/pal_index_ports.sv
module pal_index_ports
    import pal_pkg::*;
#(
    parameter int         NPORT     = 2,
    parameter int         IDX_W     = 6,
    parameter logic [7:0] ADDR_BASE = 8'h68
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                color_mode,
    input  logic [7:0]          io_addr,
    input  logic                io_wr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic [6:0]          pix_addr,
    output logic [7:0]          pix_data
);
    localparam int PW    = $clog2(NPORT);
    localparam int ENT_W = IDX_W + PW;
    localparam int NRD   = NPORT + 1;

    port_hit_t [NPORT-1:0]           hit;
    port_wr_t  [NPORT-1:0]           wr;
    logic                            any_hit;
    logic [NPORT-1:0][DATA_W-1:0]    idx_q;
    logic [NPORT-1:0][DATA_W-1:0]    dat_q;
    logic [NPORT-1:0][IDX_W-1:0]     p_raddr;
    logic [NPORT-1:0][IDX_W-1:0]     p_waddr;
    logic [NPORT-1:0]                p_we;
    logic [NRD-1:0][ENT_W-1:0]       s_raddr;
    logic [NRD-1:0][DATA_W-1:0]      s_rdata;
    logic                            s_we;
    logic [ENT_W-1:0]                s_waddr;

    pal_addr_decode #(.NPORT(NPORT), .ADDR_BASE(ADDR_BASE)) u_dec (
        .color_mode (color_mode),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .hit        (hit),
        .wr         (wr),
        .any_hit    (any_hit)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pal_index_port #(.IDX_W(IDX_W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr[p]),
            .wdata     (io_wdata),
            .ent_rdata (s_rdata[p]),
            .ent_raddr (p_raddr[p]),
            .ent_we    (p_we[p]),
            .ent_waddr (p_waddr[p]),
            .idx_q     (idx_q[p]),
            .dat_q     (dat_q[p])
        );
        assign s_raddr[p] = {PW'(p), p_raddr[p]};
    end
    assign s_raddr[NPORT] = ENT_W'(pix_addr);

    always_comb begin
        s_we    = 1'b0;
        s_waddr = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (p_we[p]) begin
                s_we    = 1'b1;
                s_waddr = {PW'(p), p_waddr[p]};
            end
        end
    end

    pal_store #(.ADDR_W(ENT_W), .NRD(NRD)) u_store (
        .clk   (clk),
        .we    (s_we),
        .waddr (s_waddr),
        .wdata (io_wdata),
        .raddr (s_raddr),
        .rdata (s_rdata)
    );

    assign pix_data = s_rdata[NPORT];

    always_comb begin
        io_rdata = READ_FILL;
        if (any_hit) begin
            for (int p = 0; p < NPORT; p++) begin
                if (hit[p].sel_idx) io_rdata = idx_q[p];
                if (hit[p].sel_dat) io_rdata = dat_q[p];
            end
        end
    end
endmodule

// File: rtl/pal_index_ports_chk.sv
module pal_index_ports_chk #(
    parameter logic [7:0] ADDR_BASE = 8'h68
) (
    input logic       clk,
    input logic       rst,
    input logic       color_mode,
    input logic [7:0] io_addr,
    input logic       io_wr,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic [7:0] bg_idx,
    input logic [7:0] obj_idx
);
    localparam logic [7:0] A_BG_IDX = ADDR_BASE;
    localparam logic [7:0] A_BG_DAT = 8'(ADDR_BASE + 1);
    localparam logic [7:0] A_TOP    = 8'(ADDR_BASE + 3);

    a_r2_idx_masked: assert property (@(posedge clk) disable iff (rst)
        (color_mode && io_wr && io_addr == A_BG_IDX) |=> (bg_idx == ($past(io_wdata) & 8'hBF)));

    a_r5_idx_advance: assert property (@(posedge clk) disable iff (rst)
        (color_mode && io_wr && io_addr == A_BG_DAT && bg_idx[7]) |=>
        (bg_idx[7] && !bg_idx[6] && bg_idx[5:0] == 6'($past(bg_idx[5:0]) + 6'd1)));

    a_r6_gated_write: assert property (@(posedge clk) disable iff (rst)
        (!color_mode && io_wr) |=> ($stable(bg_idx) && $stable(obj_idx)));

    a_r6_gated_read: assert property (@(posedge clk) disable iff (rst)
        !color_mode |-> io_rdata == 8'hFF);

    a_r7_read_quiet: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> ($stable(bg_idx) && $stable(obj_idx)));

    a_r8_outside_ff: assert property (@(posedge clk) disable iff (rst)
        (io_addr < ADDR_BASE || io_addr > A_TOP) |-> io_rdata == 8'hFF);
endmodule

bind pal_index_ports pal_index_ports_chk #(.ADDR_BASE(ADDR_BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .color_mode (color_mode),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .bg_idx     (idx_q[0]),
    .obj_idx    (idx_q[1])
);

// File: tb/tb_pal_index_ports.sv
module tb_pal_index_ports;
    localparam logic [7:0] BASE = 8'h68;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       color_mode = 1'b1;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic [6:0] pix_addr = 7'd0;
    logic [7:0] pix_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_mem [128];
    logic [7:0] m_idx [2];
    logic [7:0] m_dat [2];

    always #2.5 clk = ~clk;

    pal_index_ports dut (
        .clk(clk), .rst(rst), .color_mode(color_mode),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .pix_addr(pix_addr), .pix_data(pix_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        io_wr = 1'b0; io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic rd_pix(input int e, output logic [7:0] d);
        pix_addr = 7'(e);
        #1 d = pix_data;
    endtask

    // Model updates follow R2..R5 (color mode on, address in range).
    function automatic void m_idx_write(input int p, input logic [7:0] v);
        m_idx[p] = v & 8'hBF;
        m_dat[p] = m_mem[p*64 + int'(v[5:0])];
    endfunction

    function automatic void m_dat_write(input int p, input logic [7:0] v);
        m_mem[p*64 + int'(m_idx[p][5:0])] = v;
        m_dat[p] = v;
        if (m_idx[p][7]) m_idx[p] = {1'b1, 1'b0, 6'(m_idx[p][5:0] + 6'd1)};
    endfunction

    task automatic check_regs(input string req);
        logic [7:0] d;
        for (int p = 0; p < 2; p++) begin
            rd_reg(8'(BASE + 2*p), d);     check(req, d, m_idx[p]);
            rd_reg(8'(BASE + 2*p + 1), d); check(req, d, m_dat[p]);
        end
    endtask

    task automatic check_mem(input string req);
        logic [7:0] d;
        for (int e = 0; e < 128; e++) begin
            rd_pix(e, d);
            check(req, d, m_mem[e]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 2; p++) begin m_idx[p] = 8'h00; m_dat[p] = 8'h00; end

        // R1 reset state
        check_regs("R1");

        // R4/R5: fill both palettes with auto-increment, wrap back to start
        for (int p = 0; p < 2; p++) begin
            wr_reg(8'(BASE + 2*p), 8'h80);
            m_idx[p] = 8'h80;
            for (int i = 0; i < 64; i++) begin
                logic [7:0] v;
                v = 8'((i * 37 + p * 101 + 5) & 255);
                wr_reg(8'(BASE + 2*p + 1), v);
                m_dat_write(p, v);
            end
            rd_reg(8'(BASE + 2*p), d);
            check("R5 wrap after 64 writes", d, 8'h80);
        end
        check_mem("R4");

        // R2/R3: every index value on each port
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr_reg(8'(BASE + 2*p), 8'(v));
                m_idx_write(p, 8'(v));
                rd_reg(8'(BASE + 2*p), d);     check("R2", d, m_idx[p]);
                rd_reg(8'(BASE + 2*p + 1), d); check("R3", d, m_dat[p]);
            end
        end

        // R5: flag clear keeps index; flag set at 63 wraps to 0 with flag
        wr_reg(BASE, 8'h05); m_idx_write(0, 8'h05);
        wr_reg(8'(BASE + 1), 8'hA5); m_dat_write(0, 8'hA5);
        rd_reg(BASE, d); check("R5 no flag", d, 8'h05);
        wr_reg(8'(BASE + 2), 8'hFF); m_idx_write(1, 8'hFF);
        wr_reg(8'(BASE + 3), 8'h3C); m_dat_write(1, 8'h3C);
        rd_reg(8'(BASE + 2), d); check("R5 wrap 63", d, 8'h80);
        check_mem("R4 after single writes");

        // R7: repeated reads, no side effects
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_regs("R7");
        end

        // R9: bg index write leaves obj registers alone
        wr_reg(BASE, 8'h9A); m_idx_write(0, 8'h9A);
        check_regs("R9");

        // R6: color mode off
        @(negedge clk); color_mode = 1'b0;
        for (int a = 0; a < 4; a++) begin
            rd_reg(8'(BASE + a), d); check("R6 read", d, 8'hFF);
        end
        for (int a = 0; a < 4; a++) wr_reg(8'(BASE + a), 8'h11);
        @(negedge clk); color_mode = 1'b1;
        check_regs("R6 state kept");
        check_mem("R6 memory kept");

        // R8: neighbouring addresses
        rd_reg(8'(BASE - 1), d); check("R8 below", d, 8'hFF);
        rd_reg(8'(BASE + 4), d); check("R8 above", d, 8'hFF);
        wr_reg(8'(BASE - 1), 8'h22);
        wr_reg(8'(BASE + 4), 8'h33);
        check_regs("R8 state kept");
        check_mem("R8 memory kept");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule